// File: doc/BRIEF.md
# Masked CAM Match Array

This block keeps a small table of 64-bit words, each with a valid bit, and compares every valid word in parallel against a search key. Each 64-bit register is split into 16-bit segments. Bits can be left out of the comparison in two ways. One is a per-bit exclusion mask, taken from one of two mask registers. The other is a partition setting that turns part of every word into storage that never takes part in matching. The RAM part of the word can sit at the high end or at the low end.

A compare returns three results: whether any word matched, the lowest-numbered matching index, and whether more than one word matched. A compare starts when it is requested, or by itself when the top segment of the key or of either mask register is written. The block also reports whether every word is occupied and which index is the first free one. It can store a word at that free index, and it can clear the valid bit of the winning match.

For chaining several arrays, a match-enable and a full-enable decide whether this array adds to the chain's match and full outputs. When an enable is off, the array only forwards the chain input.

Top module: `cam_match_array`

## Requirements
- R1: After reset every word is invalid. stat_match, multi_match, match_addr, stat_full and free_addr are all 0, and match_flag follows casc_match_in.
- R2: A word whose valid bit is 0 never counts as a match, even if its contents equal the key.
- R3: mask_sel picks the exclusion mask: 1 selects mask A (reg_sel 1), 2 selects mask B (reg_sel 2), and 0 or 3 selects no mask. A mask bit of 1 removes that bit position from the comparison.
- R4: A cam_width code of k makes (k+1)×16 bits of each word take part in matching. The other segments never affect the result.
- R5: With ram_low = 0 the matching segments are the lowest ones, starting at bits 15:0. With ram_low = 1 they are the highest ones, starting at bits 63:48.
- R6: A compare starts when cmp_req is high, or when reg_wr writes segment 3 (bits 63:48) of the key (reg_sel 0), mask A (reg_sel 1) or mask B (reg_sel 2). It uses the register contents that include that same cycle's write. Its results show on the edge that samples the request, and they stay unchanged until the next compare.
- R7: match_addr is the lowest matching index, or 0 when nothing matched. multi_match is 1 when two or more words matched.
- R8: match_flag = casc_match_in OR (mf_en AND stat_match). While mf_en is 0, hp_inval has no effect.
- R9: When hp_inval is high, mf_en is 1 and stat_match is 1, the word at match_addr becomes invalid at the next edge.
- R10: stat_full is 1 when every word is valid. free_addr is the lowest invalid index, or 0 when the array is full. full_flag = casc_full_in AND (NOT ff_en OR stat_full).
- R11: nf_write stores ent_data at free_addr and marks that word valid, but only when ff_en is 1 and the array is not full. Otherwise nf_write has no effect. ent_wr takes priority over nf_write, and nf_write takes priority over hp_inval.
- R12: stat_match, multi_match and stat_full always show the true state of the array, whatever mf_en and ff_en are set to.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ent_wr | input | 1 | Write one word at ent_addr |
| ent_addr | input | 4 | Word index for ent_wr |
| ent_data | input | 64 | Word contents for ent_wr and nf_write |
| ent_valid | input | 1 | Valid bit stored by ent_wr |
| reg_wr | input | 1 | Write one register segment |
| reg_sel | input | 2 | 0 key, 1 mask A, 2 mask B, 3 none |
| reg_seg | input | 2 | Segment index, 0 = bits 15:0 |
| reg_data | input | 16 | Segment contents |
| cmp_req | input | 1 | Start a compare |
| mask_sel | input | 2 | Mask choice for compares |
| cam_width | input | 2 | Matching width code |
| ram_low | input | 1 | 1: RAM part at the low end |
| mf_en | input | 1 | Match contribution enable |
| ff_en | input | 1 | Full contribution enable |
| casc_match_in | input | 1 | Match from earlier arrays in the chain |
| casc_full_in | input | 1 | Full from earlier arrays in the chain |
| hp_inval | input | 1 | Invalidate the winning match |
| nf_write | input | 1 | Store ent_data at the free index |
| match_flag | output | 1 | Chained match output |
| stat_match | output | 1 | True local match result |
| multi_match | output | 1 | Two or more matched |
| match_addr | output | 4 | Lowest matching index |
| full_flag | output | 1 | Chained full output |
| stat_full | output | 1 | True local full state |
| free_addr | output | 4 | Lowest free index |

## Verification
The compare results (stat_match, match_addr, multi_match) are due one edge after the cycle that carries cmp_req or the segment-3 register write. The scoreboard queues the expected result while the request is being driven, and the monitor reads it just after the next rising edge. Word writes, nf_write and hp_inval take effect on the next edge, so the bench checks their results at the following falling edge, either directly through free_addr and stat_full or through a later compare. match_flag and full_flag are combinational from the inputs and the stored state, so they are sampled one nanosecond after the driving falling edge.

// File: rtl/cam_pkg.sv
package cam_pkg;
    typedef enum logic [1:0] {
        REG_KEY  = 2'd0,
        REG_MSKA = 2'd1,
        REG_MSKB = 2'd2,
        REG_NONE = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        MSEL_OFF0 = 2'd0,
        MSEL_A    = 2'd1,
        MSEL_B    = 2'd2,
        MSEL_OFF3 = 2'd3
    } msel_e;
endpackage

// File: rtl/cam_care_gen.sv
module cam_care_gen #(
    parameter int WORD_W = 64,
    parameter int SEG_W  = 16,
    localparam int NSEG  = WORD_W / SEG_W,
    localparam int CW    = $clog2(NSEG)
) (
    input  logic [CW-1:0]     cam_width,
    input  logic              ram_low,
    input  logic [1:0]        mask_sel,
    input  logic [WORD_W-1:0] mask_a,
    input  logic [WORD_W-1:0] mask_b,
    output logic [WORD_W-1:0] care
);
    import cam_pkg::*;

    logic [NSEG-1:0]   seg_on;
    logic [WORD_W-1:0] excl;

    always_comb begin
        int n_cam;
        n_cam = int'(cam_width) + 1;
        for (int s = 0; s < NSEG; s++) begin
            if (ram_low) seg_on[s] = (s >= NSEG - n_cam);
            else         seg_on[s] = (s < n_cam);
        end
    end

    always_comb begin
        case (msel_e'(mask_sel))
            MSEL_A:  excl = mask_a;
            MSEL_B:  excl = mask_b;
            default: excl = '0;
        endcase
    end

    for (genvar g = 0; g < NSEG; g++) begin : g_seg
        assign care[g*SEG_W +: SEG_W] = {SEG_W{seg_on[g]}} & ~excl[g*SEG_W +: SEG_W];
    end
endmodule

// File: rtl/cam_match_vec.sv
module cam_match_vec #(
    parameter int N = 16,
    parameter int W = 64
) (
    input  logic [W-1:0] words [N],
    input  logic [N-1:0] valid,
    input  logic [W-1:0] key,
    input  logic [W-1:0] care,
    output logic [N-1:0] hit
);
    for (genvar g = 0; g < N; g++) begin : g_line
        assign hit[g] = valid[g] && (((words[g] ^ key) & care) == '0);
    end
endmodule

// File: rtl/cam_prio_enc.sv
module cam_prio_enc #(
    parameter int N  = 16,
    localparam int AW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [AW-1:0] idx,
    output logic          multi
);
    always_comb begin
        any   = |req;
        multi = ($countones(req) > 1);
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = AW'(i);
        end
    end
endmodule

// File: rtl/cam_match_array.sv
module cam_match_array #(
    parameter int ENTRIES = 16,
    parameter int WORD_W  = 64,
    parameter int SEG_W   = 16,
    localparam int AW     = $clog2(ENTRIES),
    localparam int NSEG   = WORD_W / SEG_W,
    localparam int SW     = $clog2(NSEG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ent_wr,
    input  logic [AW-1:0]     ent_addr,
    input  logic [WORD_W-1:0] ent_data,
    input  logic              ent_valid,
    input  logic              reg_wr,
    input  logic [1:0]        reg_sel,
    input  logic [SW-1:0]     reg_seg,
    input  logic [SEG_W-1:0]  reg_data,
    input  logic              cmp_req,
    input  logic [1:0]        mask_sel,
    input  logic [SW-1:0]     cam_width,
    input  logic              ram_low,
    input  logic              mf_en,
    input  logic              ff_en,
    input  logic              casc_match_in,
    input  logic              casc_full_in,
    input  logic              hp_inval,
    input  logic              nf_write,
    output logic              match_flag,
    output logic              stat_match,
    output logic              multi_match,
    output logic [AW-1:0]     match_addr,
    output logic              full_flag,
    output logic              stat_full,
    output logic [AW-1:0]     free_addr
);
    import cam_pkg::*;

    typedef struct {
        logic [WORD_W-1:0] key;
        logic [WORD_W-1:0] msk_a;
        logic [WORD_W-1:0] msk_b;
    } opr_t;

    typedef struct {
        logic [WORD_W-1:0] word [ENTRIES];
        logic [ENTRIES-1:0] valid;
        opr_t               opr;
        logic               hit;
        logic               multi;
        logic [AW-1:0]      addr;
    } state_t;

    state_t st_q, st_d;
    opr_t   opr_d;

    logic [WORD_W-1:0]  care;
    logic [ENTRIES-1:0] line_hit;
    logic               any_hit, many_hit;
    logic [AW-1:0]      hit_idx;
    logic               free_any, free_multi;
    logic [AW-1:0]      free_idx;
    logic               trigger;

    // Operand registers: next value includes this cycle's segment write
    always_comb begin
        opr_d = st_q.opr;
        if (reg_wr) begin
            case (reg_sel_e'(reg_sel))
                REG_KEY:  opr_d.key  [reg_seg*SEG_W +: SEG_W] = reg_data;
                REG_MSKA: opr_d.msk_a[reg_seg*SEG_W +: SEG_W] = reg_data;
                REG_MSKB: opr_d.msk_b[reg_seg*SEG_W +: SEG_W] = reg_data;
                default:  ;
            endcase
        end
    end

    cam_care_gen #(.WORD_W(WORD_W), .SEG_W(SEG_W)) u_care (
        .cam_width (cam_width),
        .ram_low   (ram_low),
        .mask_sel  (mask_sel),
        .mask_a    (opr_d.msk_a),
        .mask_b    (opr_d.msk_b),
        .care      (care)
    );

    cam_match_vec #(.N(ENTRIES), .W(WORD_W)) u_match (
        .words (st_q.word),
        .valid (st_q.valid),
        .key   (opr_d.key),
        .care  (care),
        .hit   (line_hit)
    );

    cam_prio_enc #(.N(ENTRIES)) u_hit_enc (
        .req   (line_hit),
        .any   (any_hit),
        .idx   (hit_idx),
        .multi (many_hit)
    );

    cam_prio_enc #(.N(ENTRIES)) u_free_enc (
        .req   (~st_q.valid),
        .any   (free_any),
        .idx   (free_idx),
        .multi (free_multi)
    );

    assign trigger = cmp_req
                   | (reg_wr && (reg_seg == SW'(NSEG - 1))
                      && (reg_sel_e'(reg_sel) != REG_NONE));

    always_comb begin
        st_d     = st_q;
        st_d.opr = opr_d;
        if (ent_wr) begin
            st_d.word[ent_addr]  = ent_data;
            st_d.valid[ent_addr] = ent_valid;
        end else if (nf_write && ff_en && free_any) begin
            st_d.word[free_idx]  = ent_data;
            st_d.valid[free_idx] = 1'b1;
        end else if (hp_inval && mf_en && st_q.hit) begin
            st_d.valid[st_q.addr] = 1'b0;
        end
        if (trigger) begin
            st_d.hit   = any_hit;
            st_d.multi = many_hit;
            st_d.addr  = hit_idx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) st_q.word[i] <= '0;
            st_q.valid     <= '0;
            st_q.opr.key   <= '0;
            st_q.opr.msk_a <= '0;
            st_q.opr.msk_b <= '0;
            st_q.hit       <= 1'b0;
            st_q.multi     <= 1'b0;
            st_q.addr      <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stat_match  = st_q.hit;
    assign multi_match = st_q.multi;
    assign match_addr  = st_q.addr;
    assign match_flag  = casc_match_in | (mf_en & st_q.hit);
    assign stat_full   = ~free_any;
    assign free_addr   = free_idx;
    assign full_flag   = casc_full_in & (~ff_en | ~free_any);

    // Assertions
    assert_result_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !trigger |=> ($stable(stat_match) && $stable(multi_match) && $stable(match_addr)));

    assert_multi_has_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        multi_match |-> stat_match);

    assert_hp_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (hp_inval && !mf_en && !ent_wr && !nf_write) |=> $stable(st_q.valid));

    assert_hp_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (hp_inval && mf_en && stat_match && !ent_wr && !nf_write)
        |=> !st_q.valid[$past(match_addr)]);

    assert_free_is_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_full |-> !st_q.valid[free_addr]);

    assert_free_pair_R10: assert property (@(posedge clk) disable iff (!rst_n)
        free_multi |-> ($countones(st_q.valid) <= ENTRIES - 2));

    assert_nf_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (nf_write && (!ff_en || stat_full) && !ent_wr && !hp_inval) |=> $stable(st_q.valid));

    assert_nf_fills_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (nf_write && ff_en && !stat_full && !ent_wr) |=> st_q.valid[$past(free_addr)]);
endmodule

// File: tb/cam_match_array_tb_top.sv
module cam_match_array_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ent_wr = 0, ent_valid = 0, reg_wr = 0, cmp_req = 0, ram_low = 0;
    logic [3:0]  ent_addr = '0;
    logic [63:0] ent_data = '0;
    logic [1:0]  reg_sel = '0, reg_seg = '0, mask_sel = '0, cam_width = 2'd3;
    logic [15:0] reg_data = '0;
    logic        mf_en = 1, ff_en = 1, casc_match_in = 0, casc_full_in = 1;
    logic        hp_inval = 0, nf_write = 0;
    logic        match_flag, stat_match, multi_match, full_flag, stat_full;
    logic [3:0]  match_addr, free_addr;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    typedef struct {
        bit    hit;
        int    addr;
        bit    multi;
        string tag;
    } exp_t;
    exp_t sb_q[$];

    always #2 clk = ~clk;

    cam_match_array dut_i (
        .clk(clk), .rst_n(rst_n),
        .ent_wr(ent_wr), .ent_addr(ent_addr), .ent_data(ent_data), .ent_valid(ent_valid),
        .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_seg(reg_seg), .reg_data(reg_data),
        .cmp_req(cmp_req), .mask_sel(mask_sel), .cam_width(cam_width), .ram_low(ram_low),
        .mf_en(mf_en), .ff_en(ff_en), .casc_match_in(casc_match_in), .casc_full_in(casc_full_in),
        .hp_inval(hp_inval), .nf_write(nf_write),
        .match_flag(match_flag), .stat_match(stat_match), .multi_match(multi_match),
        .match_addr(match_addr), .full_flag(full_flag), .stat_full(stat_full),
        .free_addr(free_addr)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Monitor: compare results are due just after the edge sampling the request
    always begin
        @(posedge clk);
        #1;
        while (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            check({e.tag, " stat_match"},  64'(stat_match),  64'(e.hit));
            check({e.tag, " match_addr"},  64'(match_addr),  64'(e.addr));
            check({e.tag, " multi_match"}, 64'(multi_match), 64'(e.multi));
        end
    end

    task automatic push(input bit h, input int a, input bit m, input string tag);
        exp_t e;
        e.hit = h; e.addr = a; e.multi = m; e.tag = tag;
        sb_q.push_back(e);
    endtask

    task automatic put_word(input int a, input logic [63:0] d, input bit v);
        @(negedge clk);
        ent_wr = 1; ent_addr = 4'(a); ent_data = d; ent_valid = v;
        @(negedge clk);
        ent_wr = 0;
    endtask

    task automatic put_seg(input int sel, input int seg, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1; reg_sel = 2'(sel); reg_seg = 2'(seg); reg_data = d;
        @(negedge clk);
        reg_wr = 0;
    endtask

    // Full register write; the segment-3 write starts a compare (R6)
    task automatic put_reg(input int sel, input logic [63:0] v,
                           input bit h, input int a, input bit m, input string tag);
        for (int s = 0; s < 4; s++) begin
            @(negedge clk);
            reg_wr = 1; reg_sel = 2'(sel); reg_seg = 2'(s); reg_data = v[s*16 +: 16];
            if (s == 3) push(h, a, m, tag);
        end
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic compare(input bit h, input int a, input bit m, input string tag);
        @(negedge clk);
        cmp_req = 1;
        push(h, a, m, tag);
        @(negedge clk);
        cmp_req = 0;
    endtask

    task automatic pulse_nf(input logic [63:0] d);
        @(negedge clk);
        nf_write = 1; ent_data = d;
        @(negedge clk);
        nf_write = 0;
    endtask

    task automatic pulse_hp();
        @(negedge clk);
        hp_inval = 1;
        @(negedge clk);
        hp_inval = 0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk); #1;
        // R1 reset state
        check("R1 stat_match", 64'(stat_match), 0);
        check("R1 multi_match", 64'(multi_match), 0);
        check("R1 match_addr", 64'(match_addr), 0);
        check("R1 stat_full", 64'(stat_full), 0);
        check("R1 free_addr", 64'(free_addr), 0);
        check("R1 full_flag", 64'(full_flag), 0);
        check("R1 match_flag", 64'(match_flag), 0);

        put_word(0, 64'h1111_2222_3333_4444, 1);
        put_word(3, 64'hAAAA_BBBB_CCCC_DDDD, 1);
        put_word(5, 64'hAAAA_BBBB_CCCC_DDDD, 0);
        put_word(7, 64'hAAAA_BBBB_CCCC_0000, 1);
        put_word(9, 64'h5555_BBBB_CCCC_DDDD, 1);
        #1 check("R10 free_addr after writes", 64'(free_addr), 1);

        // R2 + R6: key write starts the compare; invalid word 5 excluded
        put_reg(0, 64'hAAAA_BBBB_CCCC_DDDD, 1, 3, 0, "R2 R6 key auto");
        // R3 masks
        put_reg(1, 64'h0000_0000_0000_FFFF, 1, 3, 0, "R6 maskA auto, unselected");
        mask_sel = 2'd1;
        compare(1, 3, 1, "R3 mask A");
        put_reg(2, 64'hFFFF_FFFF_FFFF_FFFF, 1, 3, 1, "R6 maskB auto");
        mask_sel = 2'd2;
        compare(1, 0, 1, "R3 mask B");
        mask_sel = 2'd3;
        compare(1, 3, 0, "R3 mask none 3");
        mask_sel = 2'd0;
        compare(1, 3, 0, "R3 mask none 0");
        // R6 hold without request
        mask_sel = 2'd2;
        repeat (3) @(negedge clk);
        #1;
        check("R6 hold stat_match", 64'(stat_match), 1);
        check("R6 hold match_addr", 64'(match_addr), 3);
        check("R6 hold multi_match", 64'(multi_match), 0);
        mask_sel = 2'd0;

        // R4 widths
        cam_width = 2'd2;
        compare(1, 3, 1, "R4 width 48 low");
        put_seg(0, 0, 16'h0000);
        cam_width = 2'd0;
        compare(1, 7, 0, "R4 R5 width 16 low");
        ram_low = 1;
        compare(1, 3, 1, "R5 width 16 high");
        cam_width = 2'd2;
        compare(1, 3, 1, "R5 width 48 high");
        ram_low = 0;
        compare(1, 7, 0, "R4 width 48 low key0");
        put_seg(0, 0, 16'hDDDD);
        cam_width = 2'd3;
        compare(1, 3, 0, "R4 width 64");

        // R8 / R12 match chain
        @(negedge clk); #1;
        check("R8 match_flag enabled", 64'(match_flag), 1);
        mf_en = 0; #1;
        check("R8 match_flag disabled", 64'(match_flag), 0);
        check("R12 stat_match disabled", 64'(stat_match), 1);
        casc_match_in = 1; #1;
        check("R8 match_flag passthrough", 64'(match_flag), 1);
        casc_match_in = 0;
        pulse_hp();
        compare(1, 3, 0, "R8 hp ignored");
        mf_en = 1;
        pulse_hp();
        compare(0, 0, 0, "R9 hp cleared word 3");
        #1 check("R9 free_addr", 64'(free_addr), 1);

        // R11 / R10 free and full
        ff_en = 0;
        pulse_nf(64'h0123_4567_89AB_CDEF);
        #1;
        check("R11 nf ignored free_addr", 64'(free_addr), 1);
        check("R10 full_flag passthrough 1", 64'(full_flag), 1);
        casc_full_in = 0; #1;
        check("R10 full_flag passthrough 0", 64'(full_flag), 0);
        casc_full_in = 1;
        put_reg(0, 64'h0123_4567_89AB_CDEF, 0, 0, 0, "R11 nf ignored compare");
        ff_en = 1;
        pulse_nf(64'h0123_4567_89AB_CDEF);
        compare(1, 1, 0, "R11 nf stored");
        #1;
        check("R10 free_addr next", 64'(free_addr), 2);
        check("R10 full_flag not full", 64'(full_flag), 0);
        for (int i = 0; i < 12; i++) pulse_nf(64'hFEED_0000_0000_0000 | 64'(i));
        #1;
        check("R10 stat_full", 64'(stat_full), 1);
        check("R10 full_flag full", 64'(full_flag), 1);
        check("R10 free_addr full", 64'(free_addr), 0);
        ff_en = 0; casc_full_in = 0; #1;
        check("R12 stat_full disabled", 64'(stat_full), 1);
        check("R10 full_flag disabled", 64'(full_flag), 0);

        repeat (3) @(negedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule